// File: doc/BRIEF.md
# Scroll and Partial-Area Line Mapper

During scan-out a display controller walks its output lines in order and must decide, for every line, which line of frame memory feeds it and whether the line is shown at all. This block makes that decision. It takes a line index and a frame-start strobe from an external timing generator and returns a memory line address together with a blank flag and the current fill colour. Pixel data never passes through the block.

A scrolling band is placed between a fixed top area of `tfa` lines and a fixed bottom area of `bfa` lines. Inside the band, the first line shows memory line `vsp` and the following lines step upward from there. The first time in a frame that the running address reaches the end of the band, it is pulled back by the band height once, and only once. A partial-display window `[psl, pel]` blanks every line outside it, and it wraps when `psl > pel`. A direction bit makes logical line numbering run from the far edge. All settings are written into pending registers through a small write port. They are copied into the active set only on a frame-start strobe, so a frame in progress never changes its mapping.

Top module: `line_mapper`

## Requirements
- R1: A line presented with `lineValid` high produces `outValid` high with its result on the next clock edge; a cycle without `lineValid` gives `outValid` low on the next edge.
- R2: While scrolling is inactive, or for a logical line `L < tfa` or `L >= 320 - bfa`, the memory line equals the input line index.
- R3: While scrolling is active, a logical line `L` in `[tfa, 320 - bfa)` maps to `vsp + (L - tfa)` until the wrap point; `vsp = tfa` therefore gives the identity mapping.
- R4: Within one frame, at the first scrolled line whose running address is at least `320 - bfa`, the band height `(320 - bfa) - tfa` is subtracted, and it stays subtracted for all later scrolled lines of that frame, which are never pulled back a second time; the frame-start strobe re-arms this.
- R5: Writes change only pending settings; the mapping, blank and fill outputs use the settings captured at the most recent frame-start strobe.
- R6: With partial mode active and `psl <= pel`, exactly the logical lines in `[psl, pel]` have `blank` low.
- R7: With partial mode active and `psl > pel`, logical lines in `[0, pel]` and `[psl, 319]` have `blank` low and all lines between them have `blank` high.
- R8: `fillWhite` follows the active fill bit (1 = white fill, 0 = black fill) for every output line; outside partial mode `blank` is always low.
- R9: With the active direction bit set, the logical line is `319 - lineIdx` for scroll and partial decisions, and the output memory line is `319 -` the mapped logical address.
- R10: Write selects: 0 = `tfa`, 1 = `bfa`, 2 = `vsp` (also arms scrolling), 3 = `psl`, 4 = `pel`, 5 = control (`wrData[0]` fill white, `wrData[1]` reversed direction), 6 = partial mode on, 7 = normal mode; selects 6 and 7 both clear `vsp` to zero and disarm scrolling, 7 also leaves partial mode.
- R11: After reset, pending and active settings are `tfa = bfa = vsp = psl = 0`, `pel = 319`, black fill, forward direction, partial and scroll off, and `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Frame-start strobe; loads pending settings, re-arms the wrap |
| lineValid | input | 1 | A line index is presented this cycle |
| lineIdx | input | 9 | Scan line index, 0 to 319 |
| wrEn | input | 1 | Setting write strobe |
| wrSel | input | 3 | Setting select (see R10) |
| wrData | input | 9 | Setting value |
| outValid | output | 1 | Result registered for the previous presented line |
| memLine | output | 9 | Frame-memory line address |
| blank | output | 1 | Line lies outside the partial window |
| fillWhite | output | 1 | Fill colour for blanked lines, 1 = white |

## Verification
The bench builds the block with its default 320 lines and 9-bit line fields, so every line of a whole frame is walked per scan and the fixed-area, band and wrap boundaries fall at their real positions. Random frames draw band edges, scroll pointers, partial windows, both fill colours and both directions. Directed frames cover a pointer far above the band end, which shows that the pull-back happens only once, and a window that wraps past line 319.

// File: rtl/line_map_pkg.sv
package line_map_pkg;

  typedef enum logic [2:0] {
    SEL_TFA     = 3'd0,
    SEL_BFA     = 3'd1,
    SEL_VSP     = 3'd2,
    SEL_PSL     = 3'd3,
    SEL_PEL     = 3'd4,
    SEL_CTRL    = 3'd5,
    SEL_PARTIAL = 3'd6,
    SEL_NORMAL  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic newFrame;
    logic lineGo;
  } mapStrobe_t;

endpackage

// File: rtl/map_ctrl.sv
module map_ctrl
  import line_map_pkg::*;
#(
  parameter int LINES = 320,
  parameter int LW    = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic          lineValid,
  input  logic          wrEn,
  input  logic [2:0]    wrSel,
  input  logic [LW-1:0] wrData,
  output mapStrobe_t    strobe,
  output logic [LW-1:0] actTfa,
  output logic [LW-1:0] actBfa,
  output logic [LW-1:0] actVsp,
  output logic [LW-1:0] actPsl,
  output logic [LW-1:0] actPel,
  output logic          actFillWhite,
  output logic          actReverse,
  output logic          actPartial,
  output logic          actScroll
);

  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

  logic [LW-1:0] pTfa, pBfa, pVsp, pPsl, pPel;
  logic          pFillWhite, pReverse, pPartial, pScroll;
  regSel_e       sel;

  assign sel = regSel_e'(wrSel);
  assign strobe.newFrame = frameStart;
  assign strobe.lineGo   = lineValid;

  // pending settings, written at any time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pTfa <= '0; pBfa <= '0; pVsp <= '0; pPsl <= '0; pPel <= LAST_LINE;
      pFillWhite <= 1'b0; pReverse <= 1'b0; pPartial <= 1'b0; pScroll <= 1'b0;
    end else if (wrEn) begin
      case (sel)
        SEL_TFA:  pTfa <= wrData;
        SEL_BFA:  pBfa <= wrData;
        SEL_VSP: begin
          pVsp    <= wrData;
          pScroll <= 1'b1;
        end
        SEL_PSL:  pPsl <= wrData;
        SEL_PEL:  pPel <= wrData;
        SEL_CTRL: begin
          pFillWhite <= wrData[0];
          pReverse   <= wrData[1];
        end
        SEL_PARTIAL: begin
          pPartial <= 1'b1;
          pVsp     <= '0;
          pScroll  <= 1'b0;
        end
        SEL_NORMAL: begin
          pPartial <= 1'b0;
          pVsp     <= '0;
          pScroll  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // active settings, loaded only at frame start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actTfa <= '0; actBfa <= '0; actVsp <= '0; actPsl <= '0; actPel <= LAST_LINE;
      actFillWhite <= 1'b0; actReverse <= 1'b0; actPartial <= 1'b0; actScroll <= 1'b0;
    end else if (frameStart) begin
      actTfa <= pTfa; actBfa <= pBfa; actVsp <= pVsp; actPsl <= pPsl; actPel <= pPel;
      actFillWhite <= pFillWhite; actReverse <= pReverse;
      actPartial <= pPartial; actScroll <= pScroll;
    end
  end

  // R5: the active set only moves on a frame-start strobe
  a_r5_frame_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable({actTfa, actBfa, actVsp, actPsl, actPel,
                             actFillWhite, actReverse, actPartial, actScroll}));

  // R10: a mode command leaves scrolling disarmed with a zero pointer
  a_r10_mode_clear: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrSel == 3'd6 || wrSel == 3'd7) |=> !pScroll && (pVsp == '0));

endmodule

// File: rtl/map_dp.sv
module map_dp
  import line_map_pkg::*;
#(
  parameter int LINES = 320,
  parameter int LW    = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  mapStrobe_t    strobe,
  input  logic [LW-1:0] lineIdx,
  input  logic [LW-1:0] actTfa,
  input  logic [LW-1:0] actBfa,
  input  logic [LW-1:0] actVsp,
  input  logic [LW-1:0] actPsl,
  input  logic [LW-1:0] actPel,
  input  logic          actFillWhite,
  input  logic          actReverse,
  input  logic          actPartial,
  input  logic          actScroll,
  output logic          outValid,
  output logic [LW-1:0] memLine,
  output logic          blank,
  output logic          fillWhite
);

  localparam int            AW     = LW + 1;
  localparam logic [AW-1:0] LAST_W = AW'(LINES - 1);
  localparam logic [AW-1:0] NUM_W  = AW'(LINES);

  logic [AW-1:0] logLine, scrollEnd, bandSpan, rawAddr, mapped, outLine;
  logic          inBand, wrapNow, wrapped, visible;

  always_comb begin
    logLine   = actReverse ? (LAST_W - {1'b0, lineIdx}) : {1'b0, lineIdx};
    scrollEnd = NUM_W - {1'b0, actBfa};
    bandSpan  = scrollEnd - {1'b0, actTfa};
    inBand    = actScroll && (logLine >= {1'b0, actTfa}) && (logLine < scrollEnd);
    rawAddr   = {1'b0, actVsp} + (logLine - {1'b0, actTfa});
    wrapNow   = inBand && !wrapped && (rawAddr >= scrollEnd);
    if (!inBand)
      mapped = logLine;
    else if (wrapped || wrapNow)
      mapped = rawAddr - bandSpan;
    else
      mapped = rawAddr;
    outLine = actReverse ? (LAST_W - mapped) : mapped;
    if (actPsl <= actPel)
      visible = (logLine >= {1'b0, actPsl}) && (logLine <= {1'b0, actPel});
    else
      visible = (logLine <= {1'b0, actPel}) || (logLine >= {1'b0, actPsl});
  end

  // one-shot wrap memory, re-armed per frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           wrapped <= 1'b0;
    else if (strobe.newFrame)            wrapped <= 1'b0;
    else if (strobe.lineGo && wrapNow)   wrapped <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      memLine   <= '0;
      blank     <= 1'b0;
      fillWhite <= 1'b0;
    end else begin
      outValid <= strobe.lineGo;
      if (strobe.lineGo) begin
        memLine   <= outLine[LW-1:0];
        blank     <= actPartial && !visible;
        fillWhite <= actFillWhite;
      end
    end
  end

  // R1: one result per presented line, one edge later
  a_r1_out_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineGo |=> outValid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lineGo |=> !outValid);

  // R2: with scrolling off the address passes straight through
  a_r2_identity: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineGo && !actScroll && !strobe.newFrame |=> memLine == $past(lineIdx));

  // R4: the wrap memory only clears at a frame start
  a_r4_one_shot: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrapped) |-> $past(strobe.newFrame));

  // R8: blanking needs partial mode
  a_r8_blank_partial: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineGo && !actPartial |=> !blank);

endmodule

// File: rtl/line_mapper.sv
module line_mapper
  import line_map_pkg::*;
#(
  parameter int LINES = 320,
  parameter int LW    = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic          lineValid,
  input  logic [LW-1:0] lineIdx,
  input  logic          wrEn,
  input  logic [2:0]    wrSel,
  input  logic [LW-1:0] wrData,
  output logic          outValid,
  output logic [LW-1:0] memLine,
  output logic          blank,
  output logic          fillWhite
);

  mapStrobe_t    strobe;
  logic [LW-1:0] actTfa, actBfa, actVsp, actPsl, actPel;
  logic          actFillWhite, actReverse, actPartial, actScroll;

  map_ctrl #(.LINES(LINES), .LW(LW)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineValid(lineValid),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .strobe(strobe),
    .actTfa(actTfa), .actBfa(actBfa), .actVsp(actVsp), .actPsl(actPsl),
    .actPel(actPel), .actFillWhite(actFillWhite), .actReverse(actReverse),
    .actPartial(actPartial), .actScroll(actScroll)
  );

  map_dp #(.LINES(LINES), .LW(LW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineIdx(lineIdx),
    .actTfa(actTfa), .actBfa(actBfa), .actVsp(actVsp), .actPsl(actPsl),
    .actPel(actPel), .actFillWhite(actFillWhite), .actReverse(actReverse),
    .actPartial(actPartial), .actScroll(actScroll),
    .outValid(outValid), .memLine(memLine), .blank(blank), .fillWhite(fillWhite)
  );

endmodule

// File: tb/tb_line_mapper.sv
module tb_line_mapper;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStart = 1'b0;
  logic       lineValid = 1'b0;
  logic [8:0] lineIdx = '0;
  logic       wrEn = 1'b0;
  logic [2:0] wrSel = '0;
  logic [8:0] wrData = '0;
  logic       outValid, blank, fillWhite;
  logic [8:0] memLine;

  int checks = 0;
  int errors = 0;

  // bench mirror of settings, built from the requirements
  int pTfa, pBfa, pVsp, pPsl, pPel, pFill, pRev, pPart, pScr;
  int aTfa, aBfa, aVsp, aPsl, aPel, aFill, aRev, aPart, aScr;
  int mWrap;

  always #2.5 clk = ~clk;

  line_mapper dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineValid(lineValid),
    .lineIdx(lineIdx), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .outValid(outValid), .memLine(memLine), .blank(blank), .fillWhite(fillWhite)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input int sel, input int data);
    wrEn = 1'b1; wrSel = 3'(sel); wrData = 9'(data);
    @(negedge clk);
    wrEn = 1'b0;
    case (sel)
      0: pTfa = data;
      1: pBfa = data;
      2: begin pVsp = data; pScr = 1; end
      3: pPsl = data;
      4: pPel = data;
      5: begin pFill = data & 1; pRev = (data >> 1) & 1; end
      6: begin pPart = 1; pVsp = 0; pScr = 0; end
      default: begin pPart = 0; pVsp = 0; pScr = 0; end
    endcase
  endtask

  task automatic newFrame();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    aTfa = pTfa; aBfa = pBfa; aVsp = pVsp; aPsl = pPsl; aPel = pPel;
    aFill = pFill; aRev = pRev; aPart = pPart; aScr = pScr;
    mWrap = 0;
  endtask

  task automatic model(input int p, output int eLine, output int eBlank);
    int l, endL, span, raw, m, vis;
    l = aRev ? 319 - p : p;
    endL = 320 - aBfa;
    span = endL - aTfa;
    if (aScr && l >= aTfa && l < endL) begin
      raw = aVsp + (l - aTfa);
      if (!mWrap && raw >= endL) mWrap = 1;
      m = mWrap ? raw - span : raw;
    end else m = l;
    eLine = (aRev ? 319 - m : m) & 511;
    if (aPsl <= aPel) vis = (l >= aPsl && l <= aPel);
    else vis = (l <= aPel || l >= aPsl);
    eBlank = (aPart && !vis) ? 1 : 0;
  endtask

  task automatic scanFrame(input string tag);
    int eL, eB;
    for (int p = 0; p < 320; p++) begin
      lineValid = 1'b1; lineIdx = 9'(p);
      @(negedge clk);
      model(p, eL, eB);
      if (p == 0) check("R1 outValid", int'(outValid), 1);
      check(tag, int'(memLine), eL);
      check(tag, int'(blank), eB);
      if (p == 0) check("R8 fillWhite", int'(fillWhite), aFill);
    end
    lineValid = 1'b0;
    @(negedge clk);
    check("R1 idle", int'(outValid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed, mode;
    seed = 7;
    void'($urandom(seed));
    pTfa = 0; pBfa = 0; pVsp = 0; pPsl = 0; pPel = 319; pFill = 0; pRev = 0; pPart = 0; pScr = 0;
    aTfa = 0; aBfa = 0; aVsp = 0; aPsl = 0; aPel = 319; aFill = 0; aRev = 0; aPart = 0; aScr = 0;
    mWrap = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 outValid", int'(outValid), 0);
    scanFrame("R11 default map");

    // R5: pending only until frame start
    writeReg(0, 10); writeReg(1, 20); writeReg(2, 50);
    scanFrame("R5 deferred");
    newFrame();
    scanFrame("R3 scrolled");

    // R3: pointer at top of band is identity
    writeReg(2, 10); newFrame();
    scanFrame("R3 vsp equals tfa");

    // R4: pointer far above band end, pulled back once only
    writeReg(0, 0); writeReg(1, 200); writeReg(2, 300); newFrame();
    scanFrame("R4 one shot");
    writeReg(0, 10); writeReg(1, 10); writeReg(2, 305); newFrame();
    scanFrame("R4 wrap mid band");

    // R6 / R7 / R8: partial windows and fill
    writeReg(6, 0); writeReg(3, 50); writeReg(4, 100); writeReg(5, 0); newFrame();
    scanFrame("R6 window");
    writeReg(3, 300); writeReg(4, 20); writeReg(5, 1); newFrame();
    scanFrame("R7 split window");

    // R9: reversed numbering with scroll and partial
    writeReg(0, 5); writeReg(1, 0); writeReg(2, 100);
    writeReg(3, 10); writeReg(4, 30); writeReg(5, 2); newFrame();
    scanFrame("R9 reversed");

    // R10: normal mode clears scroll and partial
    writeReg(7, 0); writeReg(5, 0); newFrame();
    scanFrame("R10 normal clears");
    writeReg(2, 40); writeReg(6, 0); newFrame();
    scanFrame("R10 partial clears vsp");

    // random frames
    for (int f = 0; f < 24; f++) begin
      int t, b, e;
      t = $urandom % 100; b = $urandom % 100; e = 320 - b;
      mode = $urandom % 4;
      if (mode == 0) writeReg(7, 0);
      if (mode == 1 || mode == 3) writeReg(6, 0);
      writeReg(0, t); writeReg(1, b);
      if (mode >= 2) writeReg(2, t + ($urandom % (e - t)));
      writeReg(3, $urandom % 320); writeReg(4, $urandom % 320);
      writeReg(5, $urandom % 4);
      newFrame();
      scanFrame("R3 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule